// File: doc/BRIEF.md
# Chip-Select Wait-State Controller

The controller connects a simple processor request/ready bus to an asynchronous external memory bus that is divided into eight chip-select regions. The top address bits pick the region. The remaining bits form the external byte address. Each region has a 16-bit configuration register, written and read through a halfword-wide register port. The register sets four things for its region: the wait-state count, the external port width, whether writes are permitted, and whether an idle turnaround cycle follows each external access.

A processor request is accepted in an idle cycle, and the controller then latches the region's configuration. It drives the active-low chip select, output enable or write enable and the address for N+1 cycles per external access. It holds ready low until the final cycle of the last access. When the processor access is wider than the region's port, the controller splits it into several external accesses. It assembles read data little-endian and steers write data to the low lanes. A write to a region whose write permission is clear never reaches the memory. It ends with an error flag instead.

Top module: `cs_wait_ctrl`

## Requirements
- R1: After reset every region's register reads 0x02A1, which means 1 wait state, a 16-bit port, writes permitted and the turnaround cycle enabled. Bits 15:10 and bit 8 always read 0.
- R2: Register fields: wait count in bits 4:0, port width in bits 6:5 (00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 treated as 32-bit), write permit in bit 7 and turnaround enable in bit 9. The register for region i sits at byte offset 2*i of the register port. Region i is selected by address bits 23:21 equal to i.
- R3: With a wait count of N, each external access keeps its chip select and strobe low for exactly N+1 cycles, starting the cycle after the request is accepted. The address is held stable for all of those cycles.
- R4: At most one chip select is low at any time, and it is the one for the addressed region. A read drives output enable low and a write drives write enable low. The two strobes are never low together, and neither is low without a chip select.
- R5: A processor access wider than the port is split into 2 external accesses (32-bit over 16-bit) or 4 external accesses (32-bit over 8-bit). Each split access costs the full N+1 cycles. The accesses go to ascending byte addresses base, base+width and so on, least significant part first. Read data is assembled little-endian, and access k drives write bits shifted down by k times the port width.
- R6: An access no wider than the port is a single external access. The returned read data is the memory data masked to the port width.
- R7: Ready rises only in the final cycle of the last external access, and read data is valid in that cycle. Processor size codes are 00 = byte, 01 = halfword, 10 = word.
- R8: When turnaround is enabled, one cycle with every strobe and chip select high follows each external access, including between the parts of a split access. When it is disabled, the next external access starts directly.
- R9: A write to a region without write permission drives no chip select and no write enable. Ready and the error flag are raised together for one cycle, in the cycle after acceptance. Reads from that region work normally.
- R10: The configuration used by an access is the one present when the request is accepted. A register write in the acceptance cycle applies only to later accesses.
- R11: The error flag is low in every cycle other than the R9 completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register byte offset (even) |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data for cfg_addr_i |
| req_i | input | 1 | Processor request, held until ready |
| we_i | input | 1 | Processor write |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| addr_i | input | 24 | Processor byte address |
| wdata_i | input | 32 | Processor write data |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Access complete |
| err_o | output | 1 | Write to a write-protected region |
| mem_cs_no | output | 8 | Chip selects, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_addr_o | output | 21 | External byte address |
| mem_wdata_o | output | 32 | External write data, low lanes used |
| mem_rdata_i | input | 32 | External read data |

## Verification
Two functions can meet in one clock edge: a configuration register write and the acceptance of a request to the same region. The bench drives a write that raises that region's wait count in the very cycle it presents the request. The reference model times that access with the old count, then times the next access with the new count. A wrong result would show up as ready or the chip select moving one or more cycles off the expected position. The model also checks every cycle of split accesses with and without the turnaround cycle, so an access that starts too early or a missing gap shows up as a strobe mismatch in a specific cycle.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;

  typedef struct packed {
    logic       dummy;
    logic       wr_en;
    logic [1:0] width;
    logic [4:0] ws;
  } cs_cfg_t;

  localparam logic [15:0] CFG_RESET = 16'h02A1;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_DUMMY, ST_ERR} seq_st_e;

  // code 11 is handled as 32-bit
  function automatic logic [1:0] eff_code(input logic [1:0] c);
    return (c == 2'b11) ? 2'b10 : c;
  endfunction

  function automatic logic [31:0] port_mask(input logic [1:0] wc);
    case (wc)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [15:0] pack_cfg(input cs_cfg_t c);
    return {6'b0, c.dummy, 1'b0, c.wr_en, c.width, c.ws};
  endfunction

  function automatic cs_cfg_t reset_cfg();
    cs_cfg_t c;
    c.ws    = CFG_RESET[4:0];
    c.width = CFG_RESET[6:5];
    c.wr_en = CFG_RESET[7];
    c.dummy = CFG_RESET[9];
    return c;
  endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_wait_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [15:0]           wdata_i,
  output cs_cfg_t [NUM_CS-1:0]  cfg_o
);

  logic unused_bits;
  assign unused_bits = ^{wdata_i[15:10], wdata_i[8]};

  for (genvar g = 0; g < NUM_CS; g++) begin : g_rgn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g] <= reset_cfg();
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        cfg_o[g].ws    <= wdata_i[4:0];
        cfg_o[g].width <= wdata_i[6:5];
        cfg_o[g].wr_en <= wdata_i[7];
        cfg_o[g].dummy <= wdata_i[9];
      end
    end
  end

endmodule

// File: rtl/cs_beat_seq.sv
module cs_beat_seq
  import cs_wait_pkg::*;
#(
  parameter int EXT_AW = 21,
  parameter int RGN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [RGN_W-1:0]  rgn_i,
  input  logic [EXT_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  cs_cfg_t           cfg_i,
  input  logic [31:0]       ext_rdata_i,
  output logic              cs_act_o,
  output logic [RGN_W-1:0]  rgn_o,
  output logic              oe_o,
  output logic              wr_o,
  output logic [EXT_AW-1:0] ext_addr_o,
  output logic [31:0]       ext_wdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic [31:0]       rdata_o
);

  seq_st_e           st_q;
  cs_cfg_t           cfg_q;
  logic              we_q, more_q;
  logic [RGN_W-1:0]  rgn_q;
  logic [EXT_AW-1:0] base_q;
  logic [31:0]       wdata_q, acc_q;
  logic [1:0]        beat_q;
  logic [2:0]        nbeats_q;
  logic [4:0]        cnt_q;

  logic [1:0]  wc_q, wc_in, sc_in;
  logic [2:0]  nb_in;
  logic [4:0]  shamt;
  logic [3:0]  boff;
  logic [31:0] lane;
  logic        beat_end, last_beat;

  assign wc_q  = eff_code(cfg_q.width);
  assign wc_in = eff_code(cfg_i.width);
  assign sc_in = eff_code(size_i);

  always_comb begin
    nb_in = 3'd1;
    if (sc_in > wc_in) nb_in = ((sc_in - wc_in) == 2'd1) ? 3'd2 : 3'd4;
  end

  assign shamt     = {beat_q, 3'b000} << wc_q;
  assign boff      = {2'b00, beat_q} << wc_q;
  assign lane      = (ext_rdata_i & port_mask(wc_q)) << shamt;
  assign beat_end  = (st_q == ST_ACC) && (cnt_q == cfg_q.ws);
  assign last_beat = ({1'b0, beat_q} == (nbeats_q - 3'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cfg_q    <= reset_cfg();
      we_q     <= 1'b0;
      more_q   <= 1'b0;
      rgn_q    <= '0;
      base_q   <= '0;
      wdata_q  <= '0;
      acc_q    <= '0;
      beat_q   <= '0;
      nbeats_q <= 3'd1;
      cnt_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          cfg_q    <= cfg_i;
          we_q     <= we_i;
          rgn_q    <= rgn_i;
          base_q   <= addr_i;
          wdata_q  <= wdata_i;
          nbeats_q <= nb_in;
          beat_q   <= '0;
          cnt_q    <= '0;
          acc_q    <= '0;
          st_q     <= (we_i && !cfg_i.wr_en) ? ST_ERR : ST_ACC;
        end
        ST_ACC: begin
          if (!beat_end) begin
            cnt_q <= cnt_q + 5'd1;
          end else begin
            cnt_q  <= '0;
            acc_q  <= acc_q | lane;
            more_q <= !last_beat;
            if (!last_beat) beat_q <= beat_q + 2'd1;
            if (cfg_q.dummy) st_q <= ST_DUMMY;
            else if (last_beat) st_q <= ST_IDLE;
          end
        end
        ST_DUMMY: st_q <= more_q ? ST_ACC : ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_act_o    = (st_q == ST_ACC);
  assign rgn_o       = rgn_q;
  assign oe_o        = cs_act_o && !we_q;
  assign wr_o        = cs_act_o && we_q;
  assign ext_addr_o  = base_q + EXT_AW'(boff);
  assign ext_wdata_o = wdata_q >> shamt;
  assign ready_o     = (beat_end && last_beat) || (st_q == ST_ERR);
  assign err_o       = (st_q == ST_ERR);
  assign rdata_o     = acc_q | lane;

  // R3
  cnt_within_ws_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act_o |-> (cnt_q <= cfg_q.ws));

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_o && !beat_end) |=> (cs_act_o && $stable(ext_addr_o)));

  // R8
  dummy_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_end && cfg_q.dummy) |=> (!cs_act_o && !ready_o && !oe_o && !wr_o));

  // R9
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!wr_o && !cs_act_o && ready_o));

endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl
  import cs_wait_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 8,
  localparam int RGN_W  = $clog2(NUM_CS),
  localparam int EXT_AW = ADDR_W - RGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [RGN_W:0]    cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_rdata_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic [NUM_CS-1:0] mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [EXT_AW-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);

  cs_cfg_t [NUM_CS-1:0] cfg_all;
  logic [RGN_W-1:0]     req_rgn, act_rgn;
  logic                 cs_act, oe, wr;
  logic                 unused_cfg_lsb;

  assign unused_cfg_lsb = cfg_addr_i[0];
  assign req_rgn        = addr_i[ADDR_W-1 -: RGN_W];

  cs_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_addr_i[RGN_W:1]),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_all)
  );

  assign cfg_rdata_o = pack_cfg(cfg_all[cfg_addr_i[RGN_W:1]]);

  cs_beat_seq #(.EXT_AW(EXT_AW), .RGN_W(RGN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .size_i      (size_i),
    .rgn_i       (req_rgn),
    .addr_i      (addr_i[EXT_AW-1:0]),
    .wdata_i     (wdata_i),
    .cfg_i       (cfg_all[req_rgn]),
    .ext_rdata_i (mem_rdata_i),
    .cs_act_o    (cs_act),
    .rgn_o       (act_rgn),
    .oe_o        (oe),
    .wr_o        (wr),
    .ext_addr_o  (mem_addr_o),
    .ext_wdata_o (mem_wdata_o),
    .ready_o     (ready_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o)
  );

  assign mem_cs_no = cs_act ? ~(NUM_CS'(1) << act_rgn) : '1;
  assign mem_oe_no = !oe;
  assign mem_we_no = !wr;

  // R4
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  // R4
  strobe_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> (mem_cs_no != '1));

  // R11
  err_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o);

endmodule

// File: tb/cs_wait_ctrl_bench.sv
module cs_wait_ctrl_bench;
  localparam int NUM_CS = 8;
  localparam int EXT_AW = 21;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [23:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ready_o, err_o;
  logic [7:0]  mem_cs_no;
  logic        mem_oe_no, mem_we_no;
  logic [EXT_AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  int checks = 0, fails = 0;
  int cfgm[NUM_CS];

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [EXT_AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'hA5, a[7:0] + 8'h33, a[7:0]};
  endfunction

  assign mem_rdata_i = mem_word(mem_addr_o);

  cs_wait_ctrl u_cs_wait_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .req_i(req_i), .we_i(we_i), .size_i(size_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ready_o(ready_o), .err_o(err_o),
    .mem_cs_no(mem_cs_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [15:0] v);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 4'(idx * 2); cfg_wdata_i = v;
    @(negedge clk);
    cfg_we_i = 1'b0;
    cfgm[idx] = int'(v & 16'h02FF);
  endtask

  task automatic cfg_read(input int idx, input logic [15:0] exp, input string tag);
    cfg_addr_i = 4'(idx * 2);
    #1;
    chk(tag, 32'(cfg_rdata_o), 32'(exp));
  endtask

  function automatic logic [11:0] pins();
    return {mem_cs_no, mem_oe_no, mem_we_no, ready_o, err_o};
  endfunction

  // Reference: one processor access, checked on every clock
  task automatic access(input int rgn, input bit wr, input int sz,
                        input logic [EXT_AW-1:0] off, input logic [31:0] wd,
                        input bit cfg_same, input logic [15:0] cval, input string tag);
    int v, ws, wc, sc, nb, wb;
    bit wren, dum, last;
    logic [31:0] pm, exp_rd;
    logic [EXT_AW-1:0] ea;
    v    = cfgm[rgn];
    ws   = v & 31;
    wc   = (v >> 5) & 3; if (wc == 3) wc = 2;
    wren = v[7];
    dum  = v[9];
    sc   = (sz == 3) ? 2 : sz;
    nb   = (sc > wc) ? (1 << (sc - wc)) : 1;
    wb   = 1 << wc;
    pm   = (wc == 0) ? 32'hFF : (wc == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    exp_rd = '0;
    @(negedge clk);
    chk({tag, " idle"}, 32'(pins()), 32'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}));
    req_i = 1'b1; we_i = wr; size_i = 2'(sz);
    addr_i = {3'(rgn), off}; wdata_i = wd;
    if (cfg_same) begin
      cfg_we_i = 1'b1; cfg_addr_i = 4'(rgn * 2); cfg_wdata_i = cval;
    end
    if (wr && !wren) begin
      @(negedge clk);
      cfg_we_i = 1'b0;
      // R9 error completion, no strobes
      chk({tag, " R9"}, 32'(pins()), 32'({8'hFF, 1'b1, 1'b1, 1'b1, 1'b1}));
      req_i = 1'b0;
    end else begin
      for (int k = 0; k < nb; k++) begin
        ea = off + EXT_AW'(k * wb);
        for (int c = 0; c <= ws; c++) begin
          @(negedge clk);
          cfg_we_i = 1'b0;
          last = (k == nb - 1) && (c == ws);
          chk({tag, " strobes"}, 32'(pins()),
              32'({~(8'd1 << rgn), wr, !wr, last, 1'b0}));
          chk({tag, " addr"}, 32'(mem_addr_o), 32'(ea));
          if (wr) chk({tag, " wdata"}, mem_wdata_o & pm, (wd >> (k * 8 * wb)) & pm);
          if (c == ws) exp_rd = exp_rd | ((mem_word(ea) & pm) << (k * 8 * wb));
          if (last) begin
            if (!wr) chk({tag, " rdata"}, rdata_o, exp_rd);
            req_i = 1'b0;
          end
        end
        if (dum) begin
          @(negedge clk);
          chk({tag, " R8 gap"}, 32'(pins()), 32'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}));
        end
      end
    end
    if (cfg_same) cfgm[rgn] = int'(cval & 16'h02FF);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_CS; i++) cfgm[i] = 32'h02A1;
    repeat (3) @(negedge clk);
    chk("R4 R11 reset pins", 32'(pins()), 32'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}));
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NUM_CS; i++) cfg_read(i, 16'h02A1, "R1 reset cfg");

    // R2 masked fields, offset per region
    cfg_write(5, 16'hFFFF);
    cfg_read(5, 16'h02FF, "R2 masked");
    cfg_read(4, 16'h02A1, "R2 neighbour");

    // R3 R6 R7 R8 default halfword read, single beat + gap
    access(0, 1'b0, 1, 21'h000100, '0, 1'b0, '0, "R3 R6 half rd");
    // R5 R8 word over 16-bit, gap between halves
    access(0, 1'b0, 2, 21'h000200, '0, 1'b0, '0, "R5 R8 word rd x2");
    access(0, 1'b1, 2, 21'h000204, 32'hCAFE_F00D, 1'b0, '0, "R5 word wr x2");

    // R5 R8 8-bit port, ws 3, no gap
    cfg_write(1, 16'h0083);
    access(1, 1'b1, 2, 21'h001000, 32'h1122_3344, 1'b0, '0, "R5 R8 byte wr x4");
    access(1, 1'b0, 2, 21'h001010, '0, 1'b0, '0, "R5 byte rd x4");
    // R6 byte port, byte read masked to 8 bits
    access(1, 1'b0, 0, 21'h001020, '0, 1'b0, '0, "R6 byte rd");

    // R3 ws 0, 32-bit port, back to back
    cfg_write(2, 16'h00C0);
    access(2, 1'b0, 2, 21'h0ABCDE, '0, 1'b0, '0, "R3 ws0 rd");
    access(2, 1'b1, 2, 21'h0ABCE0, 32'hDEAD_BEEF, 1'b0, '0, "R3 R4 ws0 wr");

    // R9 write-protected region
    cfg_write(7, 16'h0040);
    access(7, 1'b1, 2, 21'h000040, 32'h5555_AAAA, 1'b0, '0, "R9 R11 blocked wr");
    access(7, 1'b0, 2, 21'h000044, '0, 1'b0, '0, "R9 rd allowed");

    // R6 byte read on 16-bit port masked to 16 bits
    access(3, 1'b0, 0, 21'h000301, '0, 1'b0, '0, "R6 byte on 16");

    // R10 cfg write in acceptance cycle: old ws=1 applies, then new ws=4
    access(4, 1'b0, 1, 21'h000400, '0, 1'b1, 16'h0224, "R10 same-cycle cfg");
    access(4, 1'b0, 1, 21'h000402, '0, 1'b0, '0, "R10 new cfg");
    cfg_read(4, 16'h0224, "R10 cfg stored");

    // R3 max wait count 31, word port with gap
    access(5, 1'b0, 2, 21'h1FFFF0, '0, 1'b0, '0, "R3 ws31 rd");

    @(negedge clk);
    chk("R11 idle end", 32'(pins()), 32'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}));
    summary();
    $finish;
  end

endmodule